// File: doc/BRIEF.md
# Two-Stage Fetch Refill Sequencer

This block steps the instruction front end of a 32-bit core that runs either wide (4-byte) or narrow (2-byte) instructions. It keeps a two-entry prefetch queue and a three-state refill machine. Each step fetches one word at the program counter, shifts the queue and advances the counter. The sequencer marks the step in which the instruction at the head of the queue is handed to execution, and reports that instruction's address. The program counter always runs two instruction widths ahead of the instruction being executed.

The execute stage can redirect the flow with a flush request and a target address. A flush drops the word fetched in that cycle and restarts the two fill steps. A running cycle counter charges every fetch. The charge depends on whether the access is sequential to the last requested address. A flush is charged as one non-sequential access followed by one sequential access.

Decode and execution are outside the block. The surrounding logic supplies the width mode bit, the step enable, the flush and the two wait-state counts.

Top module: `fetch_refill_seq`

## Requirements
- R1: While reset is held and just after it, the fill state is the first fill step. `imem_addr` and `next_pc` equal `RESET_PC`, `exec_valid` is 0 and `cycle_count` is 0.
- R2: After reset or a flush, the first two enabled steps each fetch one word and execute nothing. From the third enabled step on, `exec_valid` is 1 in every enabled step. `exec_valid` is never 1 in the cycle after a flush.
- R3: `exec_insn` is the word fetched two non-flushed steps earlier, in queue order. A word fetched in narrow mode is stored with its upper 16 bits cleared.
- R4: While `exec_valid` is 1, `exec_pc` equals the current fetch address minus two instruction widths: minus 8 in wide mode, minus 4 in narrow mode.
- R5: An enabled step without flush advances `imem_addr` by one instruction width. A flush loads `imem_addr` with `flush_target` aligned to the width: bit 0 is cleared in narrow mode, and bits 1:0 are cleared in wide mode.
- R6: In a cycle with a flush, the fetched word is dropped and the fetch is not charged. Instead the counter gains 2 + `ws_seq` + `ws_nonseq`, and the last requested address becomes the aligned target plus one width.
- R7: A fetch costs 1 + `ws_seq` when its address equals the last requested address or that address plus one width. Otherwise it costs 1 + `ws_nonseq`. The fetch address then becomes the last requested address.
- R8: Reset sets the last requested address to `INVALID_ADDR` (default 0xFFFF_0000), so the first fetch after reset is charged as non-sequential.
- R9: `next_pc` is the fetch address in the first fill step, the fetch address minus one width in the second fill step, and the fetch address minus two widths in the run state.
- R10: With `step_en` low and no flush, `imem_addr`, `next_pc` and `cycle_count` hold, and `exec_valid` is 0.
- R11: `narrow` = 1 selects a 2-byte instruction width and `narrow` = 0 selects 4 bytes. The mode is sampled at every step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_en | input | 1 | Advance one pipeline step this cycle |
| narrow | input | 1 | 1: 2-byte instructions, 0: 4-byte instructions |
| imem_addr | output | AW | Fetch address (program counter) |
| imem_rdata | input | IW | Word read at `imem_addr`, same cycle |
| flush_req | input | 1 | Redirect the flow to `flush_target` |
| flush_target | input | AW | New program counter on flush |
| ws_seq | input | WSW | Wait states of a sequential access |
| ws_nonseq | input | WSW | Wait states of a non-sequential access |
| exec_valid | output | 1 | Head of queue executes this step |
| exec_insn | output | IW | Instruction being executed |
| exec_pc | output | AW | Address of the executing instruction |
| next_pc | output | AW | Address of the next instruction to execute |
| cycle_count | output | CW | Accumulated access cycles |

## Verification
The bench uses the default parameters: 32-bit addresses and words, 4-bit wait-state counts, a 32-bit counter, `RESET_PC` 0x100 and `INVALID_ADDR` 0xFFFF_0000. With these values every fill state, both widths, a mode change between steps and flushes in fill and run states can be reached within a few dozen cycles. Misaligned flush targets in both modes test the alignment rule. Unequal wait-state values make sequential and non-sequential charges distinguishable in the counter.

// File: rtl/fsq_pkg.sv
package fsq_pkg;
  typedef enum logic [1:0] {
    ST_FILL0 = 2'd0,
    ST_FILL1 = 2'd1,
    ST_RUN   = 2'd2
  } fsq_state_e;
endpackage

// File: rtl/fsq_ctrl.sv
module fsq_ctrl
  import fsq_pkg::*;
#(
  parameter int unsigned AW       = 32,
  parameter logic [AW-1:0] RESET_PC = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_en,
  input  logic          narrow,
  input  logic          flush_req,
  input  logic [AW-1:0] flush_pc,
  output fsq_state_e    state,
  output logic [AW-1:0] pc,
  output logic [AW-1:0] width
);
  fsq_state_e    state_nx;
  logic [AW-1:0] pc_nx;
  logic          upd_en;

  assign width  = narrow ? AW'(2) : AW'(4);
  assign upd_en = step_en | flush_req;

  always_comb begin
    state_nx = state;
    pc_nx    = pc;
    if (flush_req) begin
      state_nx = ST_FILL0;
      pc_nx    = flush_pc;
    end else if (step_en) begin
      pc_nx = pc + width;
      unique case (state)
        ST_FILL0: state_nx = ST_FILL1;
        ST_FILL1: state_nx = ST_RUN;
        default:  state_nx = ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_FILL0;
      pc    <= RESET_PC;
    end else if (upd_en) begin
      state <= state_nx;
      pc    <= pc_nx;
    end
  end
endmodule

// File: rtl/fsq_queue.sv
module fsq_queue #(
  parameter int unsigned IW    = 32,
  parameter int unsigned DEPTH = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          shift_en,
  input  logic          narrow,
  input  logic [IW-1:0] fetch_word,
  output logic [IW-1:0] head
);
  localparam int unsigned HW = IW / 2;

  logic [IW-1:0] slot [DEPTH];
  logic [IW-1:0] slot_nx [DEPTH];
  logic [IW-1:0] entry_word;

  assign entry_word = narrow ? {{(IW-HW){1'b0}}, fetch_word[HW-1:0]} : fetch_word;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    if (i == DEPTH - 1) begin : g_tail
      assign slot_nx[i] = entry_word;
    end else begin : g_body
      assign slot_nx[i] = slot[i+1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot[i] <= '0;
      end else if (shift_en) begin
        slot[i] <= slot_nx[i];
      end
    end
  end

  assign head = slot[0];
endmodule

// File: rtl/fsq_cost.sv
module fsq_cost #(
  parameter int unsigned AW  = 32,
  parameter int unsigned CW  = 32,
  parameter int unsigned WSW = 4,
  parameter logic [AW-1:0] INVALID_ADDR = '1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           access_en,
  input  logic           flush_req,
  input  logic [AW-1:0]  addr,
  input  logic [AW-1:0]  width,
  input  logic [AW-1:0]  flush_pc,
  input  logic [WSW-1:0] ws_seq,
  input  logic [WSW-1:0] ws_nonseq,
  output logic [CW-1:0]  count,
  output logic           seq_hit
);
  logic [AW-1:0] last_req, last_nx;
  logic [CW-1:0] count_nx;
  logic          upd_en;

  assign seq_hit = (addr == last_req) || (addr == last_req + width);
  assign upd_en  = access_en | flush_req;

  always_comb begin
    count_nx = count;
    last_nx  = last_req;
    if (flush_req) begin
      count_nx = count + CW'(2) + CW'(ws_seq) + CW'(ws_nonseq);
      last_nx  = flush_pc + width;
    end else if (access_en) begin
      count_nx = count + CW'(1) + (seq_hit ? CW'(ws_seq) : CW'(ws_nonseq));
      last_nx  = addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count    <= '0;
      last_req <= INVALID_ADDR;
    end else if (upd_en) begin
      count    <= count_nx;
      last_req <= last_nx;
    end
  end
endmodule

// File: rtl/fetch_refill_seq.sv
module fetch_refill_seq
  import fsq_pkg::*;
#(
  parameter int unsigned AW  = 32,
  parameter int unsigned IW  = 32,
  parameter int unsigned WSW = 4,
  parameter int unsigned CW  = 32,
  parameter logic [AW-1:0] RESET_PC     = AW'(32'h0000_0100),
  parameter logic [AW-1:0] INVALID_ADDR = AW'(32'hFFFF_0000)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           step_en,
  input  logic           narrow,
  output logic [AW-1:0]  imem_addr,
  input  logic [IW-1:0]  imem_rdata,
  input  logic           flush_req,
  input  logic [AW-1:0]  flush_target,
  input  logic [WSW-1:0] ws_seq,
  input  logic [WSW-1:0] ws_nonseq,
  output logic           exec_valid,
  output logic [IW-1:0]  exec_insn,
  output logic [AW-1:0]  exec_pc,
  output logic [AW-1:0]  next_pc,
  output logic [CW-1:0]  cycle_count
);
  fsq_state_e    state;
  logic [AW-1:0] pc, width, flush_pc;
  logic          fetch_keep;
  logic          seq_hit;

  assign flush_pc   = narrow ? {flush_target[AW-1:1], 1'b0}
                             : {flush_target[AW-1:2], 2'b00};
  assign fetch_keep = step_en & ~flush_req;

  fsq_ctrl #(.AW(AW), .RESET_PC(RESET_PC)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .step_en  (step_en),
    .narrow   (narrow),
    .flush_req(flush_req),
    .flush_pc (flush_pc),
    .state    (state),
    .pc       (pc),
    .width    (width)
  );

  fsq_queue #(.IW(IW), .DEPTH(2)) u_queue (
    .clk       (clk),
    .rst_n     (rst_n),
    .shift_en  (fetch_keep),
    .narrow    (narrow),
    .fetch_word(imem_rdata),
    .head      (exec_insn)
  );

  fsq_cost #(.AW(AW), .CW(CW), .WSW(WSW), .INVALID_ADDR(INVALID_ADDR)) u_cost (
    .clk      (clk),
    .rst_n    (rst_n),
    .access_en(fetch_keep),
    .flush_req(flush_req),
    .addr     (pc),
    .width    (width),
    .flush_pc (flush_pc),
    .ws_seq   (ws_seq),
    .ws_nonseq(ws_nonseq),
    .count    (cycle_count),
    .seq_hit  (seq_hit)
  );

  assign imem_addr  = pc;
  assign exec_valid = step_en && (state == ST_RUN);
  assign exec_pc    = pc - (width << 1);

  always_comb begin
    unique case (state)
      ST_FILL0: next_pc = pc;
      ST_FILL1: next_pc = pc - width;
      default:  next_pc = pc - (width << 1);
    endcase
  end
endmodule

// File: rtl/fetch_refill_seq_chk.sv
module fetch_refill_seq_chk #(
  parameter int unsigned AW = 32,
  parameter int unsigned IW = 32,
  parameter int unsigned CW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          step_en,
  input logic          narrow,
  input logic          flush_req,
  input logic [AW-1:0] flush_target,
  input logic [AW-1:0] imem_addr,
  input logic          exec_valid,
  input logic [AW-1:0] exec_pc,
  input logic [AW-1:0] next_pc,
  input logic [CW-1:0] cycle_count
);
  logic live;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live <= 1'b0;
    else        live <= 1'b1;
  end

  p_flush_no_exec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    live && flush_req |=> !exec_valid);

  p_step_advance_r5: assert property (@(posedge clk) disable iff (!rst_n)
    live && step_en && !flush_req |=>
      imem_addr == $past(imem_addr) + ($past(narrow) ? AW'(2) : AW'(4)));

  p_flush_align_r5: assert property (@(posedge clk) disable iff (!rst_n)
    live && flush_req |=>
      (imem_addr[AW-1:2] == $past(flush_target[AW-1:2])) && !imem_addr[0]);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    live && !step_en && !flush_req |=>
      $stable(imem_addr) && $stable(cycle_count) && $stable(next_pc));

  p_charge_r7: assert property (@(posedge clk) disable iff (!rst_n)
    live && step_en && !flush_req |=> cycle_count != $past(cycle_count));

  p_exec_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    exec_valid |-> exec_pc == next_pc);
endmodule

bind fetch_refill_seq fetch_refill_seq_chk #(.AW(AW), .IW(IW), .CW(CW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .step_en     (step_en),
  .narrow      (narrow),
  .flush_req   (flush_req),
  .flush_target(flush_target),
  .imem_addr   (imem_addr),
  .exec_valid  (exec_valid),
  .exec_pc     (exec_pc),
  .next_pc     (next_pc),
  .cycle_count (cycle_count)
);

// File: tb/fetch_refill_seq_tb.sv
module fetch_refill_seq_tb;
  localparam logic [31:0] RST_PC = 32'h0000_0100;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        step_en, narrow, flush_req;
  logic [31:0] imem_addr, imem_rdata, flush_target;
  logic [3:0]  ws_seq, ws_nonseq;
  logic        exec_valid;
  logic [31:0] exec_insn, exec_pc, next_pc, cycle_count;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  assign imem_rdata = {imem_addr[15:0] ^ 16'hA5A5, imem_addr[15:0] ^ 16'h3C3C};

  fetch_refill_seq u_dut (
    .clk(clk), .rst_n(rst_n), .step_en(step_en), .narrow(narrow),
    .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .flush_req(flush_req), .flush_target(flush_target),
    .ws_seq(ws_seq), .ws_nonseq(ws_nonseq),
    .exec_valid(exec_valid), .exec_insn(exec_insn), .exec_pc(exec_pc),
    .next_pc(next_pc), .cycle_count(cycle_count)
  );

  // reference state kept from the requirements
  int          m_st;
  logic [31:0] m_pc, m_last, m_cnt, q0, q1;

  function automatic logic [31:0] word_at(input logic [31:0] a, input logic nar);
    logic [31:0] w;
    w = {a[15:0] ^ 16'hA5A5, a[15:0] ^ 16'h3C3C};
    return nar ? {16'h0, w[15:0]} : w;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one enabled step, compared against the reference
  task automatic step(input logic fl, input logic [31:0] tgt, input logic nar);
    logic [31:0] w, al;
    logic        sq;
    @(negedge clk);
    step_en = 1'b1; flush_req = fl; flush_target = tgt; narrow = nar;
    #1;
    w = nar ? 32'd2 : 32'd4;
    chk("R2 exec_valid", {31'd0, exec_valid}, {31'd0, m_st == 2});
    chk("R9 next_pc", next_pc, (m_st == 0) ? m_pc : (m_st == 1) ? m_pc - w : m_pc - 2*w);
    if (m_st == 2) begin
      chk("R4 exec_pc", exec_pc, m_pc - 2*w);
      chk("R3 exec_insn", exec_insn, q0);
    end
    if (fl) begin
      al = nar ? {tgt[31:1], 1'b0} : {tgt[31:2], 2'b00};
      m_cnt = m_cnt + 2 + ws_seq + ws_nonseq;
      m_last = al + w;
      m_pc = al;
      m_st = 0;
    end else begin
      sq = (m_pc == m_last) || (m_pc == m_last + w);
      m_cnt = m_cnt + 1 + (sq ? ws_seq : ws_nonseq);
      m_last = m_pc;
      q0 = q1;
      q1 = word_at(m_pc, nar);
      m_pc = m_pc + w;
      if (m_st < 2) m_st++;
    end
    @(posedge clk); #1;
    step_en = 1'b0; flush_req = 1'b0;
    chk("R5 imem_addr", imem_addr, m_pc);
    chk("R7 cycle_count", cycle_count, m_cnt);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; step_en = 1'b0; flush_req = 1'b0; narrow = 1'b0;
    flush_target = '0; ws_seq = 4'd1; ws_nonseq = 4'd3;
    m_st = 0; m_pc = RST_PC; m_last = 32'hFFFF_0000; m_cnt = 0; q0 = 0; q1 = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 addr in reset", imem_addr, RST_PC);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 imem_addr", imem_addr, RST_PC);
    chk("R1 next_pc", next_pc, RST_PC);
    chk("R1 exec_valid", {31'd0, exec_valid}, 32'd0);
    chk("R1 cycle_count", cycle_count, 32'd0);
  endtask

  task automatic t_first_fetch();
    step(1'b0, '0, 1'b0);
    chk("R8 first fetch non-sequential", cycle_count, 32'd1 + ws_nonseq);
  endtask

  task automatic t_wide_run();
    for (int i = 0; i < 6; i++) step(1'b0, '0, 1'b0);
    chk("R2 running", {31'd0, m_st == 2}, 32'd1);
  endtask

  task automatic t_idle();
    logic [31:0] a, c, n;
    a = imem_addr; c = cycle_count; n = next_pc;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #1;
      chk("R10 exec_valid idle", {31'd0, exec_valid}, 32'd0);
    end
    @(posedge clk); #1;
    chk("R10 imem_addr held", imem_addr, a);
    chk("R10 cycle_count held", cycle_count, c);
    chk("R10 next_pc held", next_pc, n);
  endtask

  task automatic t_flush_wide();
    logic [31:0] c0;
    c0 = m_cnt;
    step(1'b1, 32'h0000_2003, 1'b0);
    chk("R6 flush charge", cycle_count - c0, 32'd2 + ws_seq + ws_nonseq);
    chk("R5 wide alignment", imem_addr, 32'h0000_2000);
    for (int i = 0; i < 4; i++) step(1'b0, '0, 1'b0);
    chk("R6 dropped word, head from target", exec_pc, 32'h0000_2008);
  endtask

  task automatic t_narrow();
    step(1'b1, 32'h0000_4001, 1'b1);
    chk("R5 narrow alignment", imem_addr, 32'h0000_4000);
    step(1'b0, '0, 1'b1);
    chk("R11 narrow width", imem_addr, 32'h0000_4002);
    for (int i = 0; i < 4; i++) step(1'b0, '0, 1'b1);
    chk("R3 narrow upper half cleared", exec_insn & 32'hFFFF_0000, 32'd0);
  endtask

  task automatic t_flush_in_fill();
    ws_seq = 4'd2; ws_nonseq = 4'd7;
    step(1'b1, 32'h0000_3000, 1'b0);
    step(1'b0, '0, 1'b0);
    step(1'b1, 32'h0000_3100, 1'b0);
    for (int i = 0; i < 4; i++) step(1'b0, '0, 1'b0);
  endtask

  task automatic t_mode_switch();
    ws_seq = 4'd0; ws_nonseq = 4'd5;
    step(1'b0, '0, 1'b1);
    step(1'b0, '0, 1'b0);
    step(1'b1, 32'h0000_5002, 1'b1);
    for (int i = 0; i < 3; i++) step(1'b0, '0, 1'b1);
  endtask

  initial begin
    t_reset();
    t_first_fetch();
    t_wide_run();
    t_idle();
    t_flush_wide();
    t_narrow();
    t_flush_in_fill();
    t_mode_switch();
    t_idle();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 10);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule